// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small fully associative cache of page translations. A requester presents a logical address, made of a page number in the upper bits and a byte offset in the lower bits, together with the identifier of the address space that is currently running. Every stored entry is compared against the page number and the identifier at the same time. Within the same cycle the block reports a hit together with the physical address, which is the stored frame number with the offset passed through unchanged. On a miss it reports only the miss. The requester then resolves the translation elsewhere and installs it through the fill port.

Each entry holds its own address-space identifier. Translations that belong to different processes can therefore stay resident together, and a context switch does not force a flush. Two kinds of invalidation are provided: one clears every entry, and one clears only the entries of a single address space. A fill goes to the lowest-numbered free slot. When no slot is free, it replaces the slot named by a rotating pointer. A fill that repeats a resident page number and identifier updates that slot in place.

Top module: `asid_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: A lookup whose page number and identifier both equal those of a valid entry reports `lk_hit`=1 in the same cycle, and `lk_pa` equals that entry's frame number followed by the low `OFF_W` bits of `lk_va`.
- R3: A lookup that matches no valid entry, including a matching page number with a different identifier, reports `lk_hit`=0 with `lk_pa` all zeros.
- R4: While at least one entry is invalid, a fill takes the lowest-numbered invalid entry and evicts no valid entry. The new entry can be looked up from the cycle after the fill edge.
- R5: A fill whose page number and identifier equal those of a valid entry overwrites that entry's frame number and takes no extra slot.
- R6: When all entries are valid, a fill of a new translation replaces the entry at a rotating pointer. The pointer starts at entry 0 after reset, advances by one on each such replacement, and wraps from the last entry to 0.
- R7: Asserting `flush_all` for one cycle invalidates every entry.
- R8: Asserting `flush_one` for one cycle invalidates exactly the entries whose identifier equals `flush_asid` and leaves every other entry valid.
- R9: A flush takes priority over a fill in the same cycle. The fill is discarded, and `flush_all` wins over `flush_one`.
- R10: Entries with the same page number and different identifiers coexist, and each lookup returns the frame that belongs to its own identifier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_va | input | VPN_W+OFF_W | Logical address to translate |
| lk_asid | input | ASID_W | Identifier of the current address space |
| lk_hit | output | 1 | Translation found (combinational) |
| lk_pa | output | PFN_W+OFF_W | Physical address on a hit, zero on a miss |
| fill_en | input | 1 | Install a translation at the next edge |
| fill_vpn | input | VPN_W | Page number to install |
| fill_asid | input | ASID_W | Identifier to install |
| fill_pfn | input | PFN_W | Frame number to install |
| flush_all | input | 1 | Invalidate every entry |
| flush_one | input | 1 | Invalidate the entries of one address space |
| flush_asid | input | ASID_W | Identifier selected by `flush_one` |

## Verification
The bench builds the block with 4 entries and keeps the default widths of 20-bit page and frame numbers, an 8-bit identifier and a 12-bit offset. With only four slots, a handful of fills brings the cache from empty to full. That makes the choice between the free-slot path and the eviction path observable at the ports: the order in which old translations disappear shows the pointer start at entry 0, step once per replacement, and wrap past the last entry. With full-width tags, the bench can place one page number under two identifiers and check that each lookup returns its own frame. It can also hit identifier-selective flushes that leave neighbouring entries resident.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   localparam int unsigned TLB_DEF_ENTRIES = 16;
   localparam int unsigned TLB_DEF_VPN_W   = 20;
   localparam int unsigned TLB_DEF_PFN_W   = 20;
   localparam int unsigned TLB_DEF_ASID_W  = 8;
   localparam int unsigned TLB_DEF_OFF_W   = 12;

   // how a fill is committed in the current cycle
   typedef enum logic [1:0] {
      WR_NONE    = 2'd0,
      WR_REFRESH = 2'd1,
      WR_FREE    = 2'd2,
      WR_EVICT   = 2'd3
   } tlb_wr_e;

endpackage

// File: rtl/tlb_lowest_idx.sv
module tlb_lowest_idx #(
   parameter int unsigned N  = 16,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [IW-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned VPN_W   = 20,
   parameter int unsigned ASID_W  = 8,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic [ENTRIES-1:0]               valid,
   input  logic [ENTRIES-1:0][VPN_W-1:0]    tag_vpn,
   input  logic [ENTRIES-1:0][ASID_W-1:0]   tag_asid,
   input  logic [VPN_W-1:0]                 key_vpn,
   input  logic [ASID_W-1:0]                key_asid,
   output logic                             hit,
   output logic [IDX_W-1:0]                 hit_idx
);

   logic [ENTRIES-1:0] hit_vec;

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign hit_vec[e] = valid[e] && (tag_vpn[e] == key_vpn) &&
                          (tag_asid[e] == key_asid);
   end

   tlb_lowest_idx #(.N(ENTRIES), .IW(IDX_W)) u_enc (
      .req (hit_vec),
      .any (hit),
      .idx (hit_idx)
   );

   // R5: the in-place update on refill keeps every key resident at most once
   a_r5_unique_match: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit_vec))
      else $error("a_r5_unique_match");

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
   parameter int unsigned ENTRIES = 16,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [ENTRIES-1:0] valid,
   input  logic               take,
   output logic               has_free,
   output logic [IDX_W-1:0]   victim_idx
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] rr_ptr;
   logic [IDX_W-1:0] free_idx;

   tlb_lowest_idx #(.N(ENTRIES), .IW(IDX_W)) u_free (
      .req (~valid),
      .any (has_free),
      .idx (free_idx)
   );

   assign victim_idx = has_free ? free_idx : rr_ptr;

   always_ff @(posedge clk) begin
      if (rst) begin
         rr_ptr <= '0;
      end else if (take && !has_free) begin
         rr_ptr <= (rr_ptr == LAST) ? '0 : rr_ptr + 1'b1;
      end
   end

   // R4: while any slot is free the chosen slot is one that holds nothing
   a_r4_prefer_free: assert property (@(posedge clk) disable iff (rst)
      has_free |-> !valid[victim_idx])
      else $error("a_r4_prefer_free");

   // R6: the pointer moves only on a replacement
   a_r6_ptr_hold: assert property (@(posedge clk) disable iff (rst)
      !(take && !has_free) |=> $stable(rr_ptr))
      else $error("a_r6_ptr_hold");

endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
   import tlb_pkg::*;
#(
   parameter int unsigned ENTRIES = TLB_DEF_ENTRIES,
   parameter int unsigned VPN_W   = TLB_DEF_VPN_W,
   parameter int unsigned PFN_W   = TLB_DEF_PFN_W,
   parameter int unsigned ASID_W  = TLB_DEF_ASID_W,
   parameter int unsigned OFF_W   = TLB_DEF_OFF_W,
   localparam int unsigned VA_W   = VPN_W + OFF_W,
   localparam int unsigned PA_W   = PFN_W + OFF_W,
   localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic [PA_W-1:0]   lk_pa,
   input  logic              fill_en,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [ASID_W-1:0] fill_asid,
   input  logic [PFN_W-1:0]  fill_pfn,
   input  logic              flush_all,
   input  logic              flush_one,
   input  logic [ASID_W-1:0] flush_asid
);

   initial begin
      assert (ENTRIES >= 2) else $error("ENTRIES must be at least 2");
      assert (VPN_W >= 1 && PFN_W >= 1 && ASID_W >= 1 && OFF_W >= 1)
         else $error("field widths must be positive");
   end

   logic [ENTRIES-1:0]             valid;
   logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn;
   logic [ENTRIES-1:0][ASID_W-1:0] tag_asid;
   logic [ENTRIES-1:0][PFN_W-1:0]  tag_pfn;
   logic [ENTRIES-1:0]             fl_vec;

   logic             lk_hit_i;
   logic [IDX_W-1:0] lk_idx;
   logic             dup_hit;
   logic [IDX_W-1:0] dup_idx;
   logic             has_free;
   logic [IDX_W-1:0] victim_idx;
   logic             take;
   logic [IDX_W-1:0] wr_idx;
   tlb_wr_e          wr_kind;

   // lookup search
   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lk_cam (
      .clk      (clk),
      .rst      (rst),
      .valid    (valid),
      .tag_vpn  (tag_vpn),
      .tag_asid (tag_asid),
      .key_vpn  (lk_va[VA_W-1:OFF_W]),
      .key_asid (lk_asid),
      .hit      (lk_hit_i),
      .hit_idx  (lk_idx)
   );

   // search for a resident copy of the fill key
   tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_cam (
      .clk      (clk),
      .rst      (rst),
      .valid    (valid),
      .tag_vpn  (tag_vpn),
      .tag_asid (tag_asid),
      .key_vpn  (fill_vpn),
      .key_asid (fill_asid),
      .hit      (dup_hit),
      .hit_idx  (dup_idx)
   );

   tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
      .clk        (clk),
      .rst        (rst),
      .valid      (valid),
      .take       (take),
      .has_free   (has_free),
      .victim_idx (victim_idx)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_flm
      assign fl_vec[e] = (tag_asid[e] == flush_asid);
   end

   always_comb begin
      if (!fill_en || flush_all || flush_one) wr_kind = WR_NONE;
      else if (dup_hit)                        wr_kind = WR_REFRESH;
      else if (has_free)                       wr_kind = WR_FREE;
      else                                     wr_kind = WR_EVICT;
   end

   assign take   = (wr_kind == WR_FREE) || (wr_kind == WR_EVICT);
   assign wr_idx = dup_hit ? dup_idx : victim_idx;

   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= '0;
      end else if (flush_all) begin
         valid <= '0;
      end else if (flush_one) begin
         valid <= valid & ~fl_vec;
      end else if (wr_kind != WR_NONE) begin
         valid[wr_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_kind != WR_NONE) begin
         tag_vpn[wr_idx]  <= fill_vpn;
         tag_asid[wr_idx] <= fill_asid;
         tag_pfn[wr_idx]  <= fill_pfn;
      end
   end

   assign lk_hit = lk_hit_i;
   assign lk_pa  = lk_hit_i ? {tag_pfn[lk_idx], lk_va[OFF_W-1:0]} : '0;

   // R1: the cycle after reset is released, nothing is resident
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (valid == '0))
      else $error("a_r1_empty_after_reset");

   // R2: the offset passes through untouched on a hit
   a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
      lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]))
      else $error("a_r2_offset_kept");

   // R3: a miss drives a zero address
   a_r3_miss_zero: assert property (@(posedge clk) disable iff (rst)
      !lk_hit |-> (lk_pa == '0))
      else $error("a_r3_miss_zero");

   // R7: a global flush leaves nothing valid
   a_r7_flush_all_empty: assert property (@(posedge clk) disable iff (rst)
      flush_all |=> (valid == '0))
      else $error("a_r7_flush_all_empty");

   // R8: no entry of the flushed identifier survives
   a_r8_asid_gone: assert property (@(posedge clk) disable iff (rst)
      (flush_one && !flush_all) |=> ((valid & $past(fl_vec)) == '0))
      else $error("a_r8_asid_gone");

   // R9: a fill in a flush cycle writes no tag
   a_r9_flush_blocks_fill: assert property (@(posedge clk) disable iff (rst)
      (fill_en && (flush_all || flush_one)) |=>
         ($stable(tag_vpn) && $stable(tag_asid) && $stable(tag_pfn)))
      else $error("a_r9_flush_blocks_fill");

endmodule

// File: tb/asid_tlb_tb.sv
module asid_tlb_tb;

   localparam int unsigned ENTRIES = 4;
   localparam int unsigned VPN_W   = 20;
   localparam int unsigned PFN_W   = 20;
   localparam int unsigned ASID_W  = 8;
   localparam int unsigned OFF_W   = 12;
   localparam int unsigned VA_W    = VPN_W + OFF_W;
   localparam int unsigned PA_W    = PFN_W + OFF_W;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [VA_W-1:0]   lk_va = '0;
   logic [ASID_W-1:0] lk_asid = '0;
   logic              lk_hit;
   logic [PA_W-1:0]   lk_pa;
   logic              fill_en = 1'b0;
   logic [VPN_W-1:0]  fill_vpn = '0;
   logic [ASID_W-1:0] fill_asid = '0;
   logic [PFN_W-1:0]  fill_pfn = '0;
   logic              flush_all = 1'b0;
   logic              flush_one = 1'b0;
   logic [ASID_W-1:0] flush_asid = '0;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;   // 50 MHz

   asid_tlb #(
      .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W),
      .ASID_W(ASID_W), .OFF_W(OFF_W)
   ) u_dut (
      .clk(clk), .rst(rst), .lk_va(lk_va), .lk_asid(lk_asid),
      .lk_hit(lk_hit), .lk_pa(lk_pa), .fill_en(fill_en),
      .fill_vpn(fill_vpn), .fill_asid(fill_asid), .fill_pfn(fill_pfn),
      .flush_all(flush_all), .flush_one(flush_one), .flush_asid(flush_asid)
   );

   typedef struct packed {
      logic             is_fill;
      logic [VPN_W-1:0] vpn;
      logic [ASID_W-1:0] asid;
      logic [PFN_W-1:0] pfn;
      logic             exp_hit;
      logic [3:0]       req;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VT [NV] = '{
      '{1'b0, 20'h00010, 8'h01, 20'h00000, 1'b0, 4'd1},  // R1 empty
      '{1'b1, 20'h00010, 8'h01, 20'hAAAAA, 1'b0, 4'd2},
      '{1'b0, 20'h00010, 8'h01, 20'hAAAAA, 1'b1, 4'd2},  // R2 hit
      '{1'b0, 20'h00010, 8'h02, 20'h00000, 1'b0, 4'd3},  // R3 other ASID
      '{1'b1, 20'h00010, 8'h02, 20'h55555, 1'b0, 4'd10},
      '{1'b0, 20'h00010, 8'h02, 20'h55555, 1'b1, 4'd10}, // R10 own frame
      '{1'b0, 20'h00010, 8'h01, 20'hAAAAA, 1'b1, 4'd10}, // R10 own frame
      '{1'b0, 20'h00011, 8'h01, 20'h00000, 1'b0, 4'd3}   // R3 other page
   };

   task automatic check(input bit ok, input string req,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic do_fill(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                          input logic [PFN_W-1:0] pfn);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic do_flush(input bit all, input bit one, input logic [ASID_W-1:0] asid);
      @(negedge clk);
      flush_all = all; flush_one = one; flush_asid = asid;
      @(negedge clk);
      flush_all = 1'b0; flush_one = 1'b0;
   endtask

   task automatic look(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                       input bit exp_hit, input logic [PFN_W-1:0] exp_pfn,
                       input string req);
      logic [OFF_W-1:0] off;
      logic [PA_W-1:0]  exp_pa;
      @(negedge clk);
      off     = vpn[OFF_W-1:0] ^ 12'h5A3;
      lk_va   = {vpn, off};
      lk_asid = asid;
      #2;
      exp_pa = exp_hit ? {exp_pfn, off} : '0;
      check(lk_hit == exp_hit && lk_pa == exp_pa, req,
            {31'd0, lk_hit, lk_pa}, {31'd0, exp_hit, exp_pa});
   endtask

   initial begin : watchdog
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      do_reset();

      // table walk: R1, R2, R3, R10
      for (int i = 0; i < NV; i++) begin
         if (VT[i].is_fill) do_fill(VT[i].vpn, VT[i].asid, VT[i].pfn);
         else look(VT[i].vpn, VT[i].asid, VT[i].exp_hit, VT[i].pfn,
                   $sformatf("R%0d vec%0d", VT[i].req, i));
      end

      // R1: reset empties the table
      do_reset();
      look(20'h00010, 8'h01, 1'b0, '0, "R1 after reset");
      look(20'h00010, 8'h02, 1'b0, '0, "R1 after reset");

      // R4: four fills into four free slots evict nothing
      do_fill(20'h00100, 8'h03, 20'h10000);
      do_fill(20'h00101, 8'h03, 20'h10001);
      do_fill(20'h00102, 8'h04, 20'h10002);
      do_fill(20'h00103, 8'h03, 20'h10003);
      for (int k = 0; k < 4; k++)
         look(20'h00100 + k, (k == 2) ? 8'h04 : 8'h03, 1'b1, 20'h10000 + k, "R4 fill to free");
      // R8: flush identifier 3 only
      do_flush(1'b0, 1'b1, 8'h03);
      look(20'h00100, 8'h03, 1'b0, '0, "R8 flushed asid");
      look(20'h00103, 8'h03, 1'b0, '0, "R8 flushed asid");
      look(20'h00102, 8'h04, 1'b1, 20'h10002, "R8 other asid kept");
      // R4: refill holes without evicting the survivor
      do_fill(20'h00200, 8'h05, 20'h20000);
      do_fill(20'h00201, 8'h05, 20'h20001);
      do_fill(20'h00202, 8'h05, 20'h20002);
      look(20'h00102, 8'h04, 1'b1, 20'h10002, "R4 survivor kept");
      look(20'h00202, 8'h05, 1'b1, 20'h20002, "R4 hole refilled");
      // R7: flush everything
      do_flush(1'b1, 1'b0, 8'h00);
      look(20'h00102, 8'h04, 1'b0, '0, "R7 flush all");
      look(20'h00200, 8'h05, 1'b0, '0, "R7 flush all");

      // R5: duplicate fill updates in place and keeps the slot count
      do_reset();
      do_fill(20'h00A00, 8'h07, 20'h0A000);
      do_fill(20'h00A01, 8'h07, 20'h0A001);
      do_fill(20'h00A02, 8'h07, 20'h0A002);
      do_fill(20'h00A00, 8'h07, 20'h0BEEF);
      look(20'h00A00, 8'h07, 1'b1, 20'h0BEEF, "R5 frame updated");
      do_fill(20'h00A03, 8'h07, 20'h0A003);
      look(20'h00A01, 8'h07, 1'b1, 20'h0A001, "R5 no slot taken");
      look(20'h00A02, 8'h07, 1'b1, 20'h0A002, "R5 no slot taken");
      look(20'h00A03, 8'h07, 1'b1, 20'h0A003, "R5 no slot taken");
      look(20'h00A00, 8'h07, 1'b1, 20'h0BEEF, "R5 no slot taken");

      // R6: round-robin replacement, slots 0..3 hold A0..A3
      do_fill(20'h00B00, 8'h07, 20'h0B000);
      look(20'h00A00, 8'h07, 1'b0, '0, "R6 slot0 evicted");
      look(20'h00A01, 8'h07, 1'b1, 20'h0A001, "R6 slot1 kept");
      look(20'h00B00, 8'h07, 1'b1, 20'h0B000, "R6 new entry");
      do_fill(20'h00B01, 8'h07, 20'h0B001);
      look(20'h00A01, 8'h07, 1'b0, '0, "R6 slot1 evicted");
      look(20'h00A02, 8'h07, 1'b1, 20'h0A002, "R6 slot2 kept");
      do_fill(20'h00B02, 8'h07, 20'h0B002);
      do_fill(20'h00B03, 8'h07, 20'h0B003);
      look(20'h00A03, 8'h07, 1'b0, '0, "R6 slot3 evicted");
      do_fill(20'h00B04, 8'h07, 20'h0B004);
      look(20'h00B00, 8'h07, 1'b0, '0, "R6 pointer wrapped");
      look(20'h00B01, 8'h07, 1'b1, 20'h0B001, "R6 after wrap");
      look(20'h00B04, 8'h07, 1'b1, 20'h0B004, "R6 after wrap");

      // R9: fill in the same cycle as a flush is discarded
      do_reset();
      do_fill(20'h00C00, 8'h09, 20'h0C000);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = 20'h00C01; fill_asid = 8'h09; fill_pfn = 20'h0C001;
      flush_all = 1'b1;
      @(negedge clk);
      fill_en = 1'b0; flush_all = 1'b0;
      look(20'h00C00, 8'h09, 1'b0, '0, "R9 flush applied");
      look(20'h00C01, 8'h09, 1'b0, '0, "R9 fill dropped");
      do_fill(20'h00C02, 8'h09, 20'h0C002);
      @(negedge clk);
      fill_en = 1'b1; fill_vpn = 20'h00C03; fill_asid = 8'h0A; fill_pfn = 20'h0C003;
      flush_one = 1'b1; flush_asid = 8'h01;
      @(negedge clk);
      fill_en = 1'b0; flush_one = 1'b0;
      look(20'h00C03, 8'h0A, 1'b0, '0, "R9 fill dropped by asid flush");
      look(20'h00C02, 8'h09, 1'b1, 20'h0C002, "R9 other asid kept");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule